// File: doc/BRIEF.md
# Debug Bus Access Router

This block is the slave-side entry point of a debug register bus driven by a single master. Each request carries a word address of parameterised width (7 to 32 bits), a read/write flag and write data. The router classifies every accepted request. Requests in the lowest address window go to the local debug module's register file. Requests at or above a configured next-module base go, with the address unchanged, to an expansion port that can chain further debug modules. One word of the local window holds the next-module register. The router answers reads of that word itself, and a value of zero there means no further module exists.

While the platform (non-debug) reset or any external reset is asserted, only the control register at word 0x10 is reachable. Every other access is refused without side effects. A refused read returns zero, a refused write is dropped, and both complete with the error flag set. Request and response channels both use a valid/ready handshake. The router keeps exactly one transaction in flight, so responses come back in request order. The register contents themselves and the transport that feeds the bus are outside this block.

Top module: `dbgbus_router`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows rsp_valid=0, exp_req_valid=0 and req_ready=1, including when reset arrives in the middle of a forwarded transaction.
- R2: A read accepted with address below the next-module base, other than word 0x1D, pulses loc_sel with loc_write=0 in the accept cycle and completes with rsp_rdata equal to loc_rdata from that cycle and rsp_err=0.
- R3: A write accepted in the local window, other than word 0x1D, pulses loc_sel with loc_write=1 and loc_wdata equal to req_wdata, and completes with rsp_rdata=0 and rsp_err=0.
- R4: Word 0x1D is the next-module register. A read returns NEXT_BASE zero-extended, without pulsing loc_sel. A write to it completes with rsp_err=0, pulses no loc_sel and leaves the read value unchanged.
- R5: When NEXT_BASE is non-zero, an accepted request with address at or above NEXT_BASE raises exp_req_valid in the next cycle, with exp_addr, exp_write and exp_wdata equal to the request. The response then carries exp_rsp_rdata and exp_rsp_err, and loc_sel stays low.
- R6: When NEXT_BASE is zero, every address, including the top of the address space, is routed locally, and word 0x1D reads 0.
- R7: While sysrst_active or extrst_active is 1, an accepted request to any word other than 0x10 (including the status word 0x11 and expansion addresses) pulses no loc_sel, raises no exp_req_valid, and completes with rsp_rdata=0 and rsp_err=1.
- R8: A request to the control word 0x10 is routed to the local register file whether or not a reset gate input is active.
- R9: req_ready is 0 from acceptance until the response handshake. While rsp_valid=1 and rsp_ready=0, rsp_valid, rsp_rdata and rsp_err hold their values.
- R10: While exp_req_valid=1 and exp_req_ready=0, exp_req_valid stays 1 and exp_addr, exp_write and exp_wdata hold. After exp_req_ready, exp_rsp_ready is 1 until exp_rsp_valid is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sysrst_active | input | 1 | Platform (non-debug) reset is asserted |
| extrst_active | input | 1 | An external reset is asserted |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | ADDR_W | Request word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | DATA_W | Read data (0 for writes and refused reads) |
| rsp_err | output | 1 | Access refused or expansion error |
| loc_sel | output | 1 | One-cycle access strobe to the local register file |
| loc_write | output | 1 | Local access is a write |
| loc_addr | output | ADDR_W | Local word address |
| loc_wdata | output | DATA_W | Local write data |
| loc_rdata | input | DATA_W | Local read data, valid in the strobe cycle |
| exp_req_valid | output | 1 | Expansion request valid |
| exp_req_ready | input | 1 | Expansion port accepts the request |
| exp_addr | output | ADDR_W | Expansion word address (unchanged) |
| exp_write | output | 1 | Expansion access is a write |
| exp_wdata | output | DATA_W | Expansion write data |
| exp_rsp_valid | input | 1 | Expansion response valid |
| exp_rsp_ready | output | 1 | Router accepts the expansion response |
| exp_rsp_rdata | input | DATA_W | Expansion read data |
| exp_rsp_err | input | 1 | Expansion error flag |

## Verification
The hardest case to reach from the ports is a reset that lands while a forwarded request is still waiting for the expansion port. The bench gets there by issuing an expansion access and holding exp_req_ready low, then pulling rst_n low in that window. Refusal during reset is also hard to see, because its only visible effect is an absence of strobes. The bench therefore samples loc_sel in the accept cycle and exp_req_valid in the cycle after, for refused accesses to the status word, an ordinary local word and an expansion address. It also checks that the control word still reaches the register file under both reset inputs.

// File: rtl/dbgbus_pkg.sv
// Package: shared types for the debug bus access router.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dbgbus_pkg;

    // Destination chosen for one request
    typedef enum logic [1:0] {
        RT_LOCAL   = 2'd0,
        RT_NEXTREG = 2'd1,
        RT_EXPAND  = 2'd2,
        RT_BLOCKED = 2'd3
    } route_t;

    // Transaction sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_EXP_REQ = 2'd1,
        SQ_EXP_RSP = 2'd2,
        SQ_RESP    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dbgbus_decode.sv
// Module: address and reset-gate decoder.
// Classifies a request address into one of four routes. A gated
// (reset active) request to anything but the control word is
// refused first. Then the expansion window, then the next-module
// word, then the local window.
// Assumes: NEXT_REG_ADDR and CTRL_ADDR lie below NEXT_BASE when
// NEXT_BASE is non-zero.
module dbgbus_decode
    import dbgbus_pkg::*;
#(
    parameter int          ADDR_W        = 7,
    parameter logic [31:0] NEXT_BASE     = 32'h40,
    parameter int unsigned CTRL_ADDR     = 32'h10,
    parameter int unsigned NEXT_REG_ADDR = 32'h1D
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              gate,
    output route_t            route
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NEXT_REG_ADDR);

    logic is_ctrl;
    logic is_nreg;
    logic is_far;

    assign is_ctrl = (addr == CTRL_A);
    assign is_nreg = (addr == NREG_A);

    // Expansion window exists only when a next module is configured
    generate
        if (NEXT_BASE == 32'd0) begin : g_no_next
            assign is_far = 1'b0;
        end else begin : g_next
            localparam logic [ADDR_W-1:0] BASE_A = NEXT_BASE[ADDR_W-1:0];
            assign is_far = (addr >= BASE_A);
        end
    endgenerate

    // Priority classification of the request
    always_comb begin
        if (gate && !is_ctrl) begin
            route = RT_BLOCKED;
        end else if (is_far) begin
            route = RT_EXPAND;
        end else if (is_nreg) begin
            route = RT_NEXTREG;
        end else begin
            route = RT_LOCAL;
        end
    end

endmodule

// File: rtl/dbgbus_local_port.sv
// Module: local register-file port and in-router result mux.
// Produces the one-cycle strobe toward the register file and the
// response word for every route that completes without the
// expansion port: local reads, next-module reads and refusals.
// Assumes: loc_rdata is combinational from loc_addr within the
// strobe cycle.
module dbgbus_local_port
    import dbgbus_pkg::*;
#(
    parameter int          ADDR_W    = 7,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] NEXT_BASE = 32'h40
) (
    input  logic              accept,
    input  route_t            route,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              loc_sel,
    output logic              loc_write,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err
);

    localparam logic [DATA_W-1:0] NEXT_WORD = DATA_W'(NEXT_BASE);

    // Strobe only on an accepted request routed to the register file
    assign loc_sel   = accept && (route == RT_LOCAL);
    assign loc_write = req_write;
    assign loc_addr  = req_addr;
    assign loc_wdata = req_wdata;

    // Response word for routes answered inside the router
    always_comb begin
        res_data = '0;
        res_err  = 1'b0;
        unique case (route)
            RT_LOCAL:   res_data = req_write ? '0 : loc_rdata;
            RT_NEXTREG: res_data = req_write ? '0 : NEXT_WORD;
            RT_BLOCKED: res_err  = 1'b1;
            RT_EXPAND:  res_data = '0;
            default:    res_data = '0;
        endcase
    end

endmodule

// File: rtl/dbgbus_seq.sv
// Module: single-outstanding transaction sequencer.
// Accepts one request at a time. Local results are registered into
// the response stage at once. Expansion requests are latched and
// presented on the expansion port, and its answer is captured.
// The response is held until the master takes it.
// Assumes: synchronous active-low reset; the expansion port gives
// exactly one response for each request it accepts.
module dbgbus_seq
    import dbgbus_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  route_t            route,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_err,
    output logic              req_ready,
    output logic              accept,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              exp_req_valid,
    input  logic              exp_req_ready,
    output logic [ADDR_W-1:0] exp_addr,
    output logic              exp_write,
    output logic [DATA_W-1:0] exp_wdata,
    input  logic              exp_rsp_valid,
    output logic              exp_rsp_ready,
    input  logic [DATA_W-1:0] exp_rsp_rdata,
    input  logic              exp_rsp_err
);

    seq_state_t        state_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;
    logic [ADDR_W-1:0] xaddr_q;
    logic              xwrite_q;
    logic [DATA_W-1:0] xwdata_q;

    // Handshake signals decoded from the state
    assign req_ready     = (state_q == SQ_IDLE);
    assign accept        = req_valid && req_ready;
    assign rsp_valid     = (state_q == SQ_RESP);
    assign exp_req_valid = (state_q == SQ_EXP_REQ);
    assign exp_rsp_ready = (state_q == SQ_EXP_RSP);
    assign rsp_rdata     = data_q;
    assign rsp_err       = err_q;
    assign exp_addr      = xaddr_q;
    assign exp_write     = xwrite_q;
    assign exp_wdata     = xwdata_q;

    // State advance for one transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        state_q <= (route == RT_EXPAND) ? SQ_EXP_REQ : SQ_RESP;
                    end
                end
                SQ_EXP_REQ: if (exp_req_ready) state_q <= SQ_EXP_RSP;
                SQ_EXP_RSP: if (exp_rsp_valid) state_q <= SQ_RESP;
                SQ_RESP:    if (rsp_ready)     state_q <= SQ_IDLE;
                default:    state_q <= SQ_IDLE;
            endcase
        end
    end

    // Response register: load from local result or expansion answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= 1'b0;
        end else if (accept && (route != RT_EXPAND)) begin
            data_q <= res_data;
            err_q  <= res_err;
        end else if (exp_rsp_ready && exp_rsp_valid) begin
            data_q <= exp_rsp_rdata;
            err_q  <= exp_rsp_err;
        end
    end

    // Expansion request latch, loaded on an accepted far request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xaddr_q  <= '0;
            xwrite_q <= 1'b0;
            xwdata_q <= '0;
        end else if (accept && (route == RT_EXPAND)) begin
            xaddr_q  <= req_addr;
            xwrite_q <= req_write;
            xwdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/dbgbus_router.sv
// Module: debug bus access router (top).
// Decodes each request on a single-master debug register bus, gates
// it against platform and external reset, and sends it to the local
// register file, the next-module register or the expansion port.
// Assumes: one master; synchronous active-low reset; the address
// width lies between 7 and 32 bits.
module dbgbus_router
    import dbgbus_pkg::*;
#(
    parameter int          ADDR_W        = 7,
    parameter int          DATA_W        = 32,
    parameter logic [31:0] NEXT_BASE     = 32'h40,
    parameter int unsigned CTRL_ADDR     = 32'h10,
    parameter int unsigned NEXT_REG_ADDR = 32'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysrst_active,
    input  logic              extrst_active,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              loc_sel,
    output logic              loc_write,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    output logic              exp_req_valid,
    input  logic              exp_req_ready,
    output logic [ADDR_W-1:0] exp_addr,
    output logic              exp_write,
    output logic [DATA_W-1:0] exp_wdata,
    input  logic              exp_rsp_valid,
    output logic              exp_rsp_ready,
    input  logic [DATA_W-1:0] exp_rsp_rdata,
    input  logic              exp_rsp_err
);

    route_t            route;
    logic              gate;
    logic              accept;
    logic [DATA_W-1:0] res_data;
    logic              res_err;

    // Either reset source closes the gate
    assign gate = sysrst_active || extrst_active;

    dbgbus_decode #(
        .ADDR_W        (ADDR_W),
        .NEXT_BASE     (NEXT_BASE),
        .CTRL_ADDR     (CTRL_ADDR),
        .NEXT_REG_ADDR (NEXT_REG_ADDR)
    ) u_decode (
        .addr  (req_addr),
        .gate  (gate),
        .route (route)
    );

    dbgbus_local_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NEXT_BASE (NEXT_BASE)
    ) u_local (
        .accept    (accept),
        .route     (route),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .loc_rdata (loc_rdata),
        .loc_sel   (loc_sel),
        .loc_write (loc_write),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .res_data  (res_data),
        .res_err   (res_err)
    );

    dbgbus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .route         (route),
        .res_data      (res_data),
        .res_err       (res_err),
        .req_ready     (req_ready),
        .accept        (accept),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_rdata     (rsp_rdata),
        .rsp_err       (rsp_err),
        .exp_req_valid (exp_req_valid),
        .exp_req_ready (exp_req_ready),
        .exp_addr      (exp_addr),
        .exp_write     (exp_write),
        .exp_wdata     (exp_wdata),
        .exp_rsp_valid (exp_rsp_valid),
        .exp_rsp_ready (exp_rsp_ready),
        .exp_rsp_rdata (exp_rsp_rdata),
        .exp_rsp_err   (exp_rsp_err)
    );

endmodule

// File: rtl/dbgbus_router_chk.sv
// Module: protocol checker for the debug bus access router.
// Relates the router's ports over time; attached with bind below.
// Assumes: same parameters as the router instance it watches.
module dbgbus_router_chk #(
    parameter int          ADDR_W        = 7,
    parameter int          DATA_W        = 32,
    parameter logic [31:0] NEXT_BASE     = 32'h40,
    parameter int unsigned CTRL_ADDR     = 32'h10,
    parameter int unsigned NEXT_REG_ADDR = 32'h1D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sysrst_active,
    input logic              extrst_active,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err,
    input logic              loc_sel,
    input logic              exp_req_valid,
    input logic              exp_req_ready,
    input logic [ADDR_W-1:0] exp_addr,
    input logic              exp_write,
    input logic [DATA_W-1:0] exp_wdata
);

    logic acc;
    logic gated;
    logic far;
    logic to_ctrl;
    logic to_nreg;

    assign acc     = req_valid && req_ready;
    assign gated   = sysrst_active || extrst_active;
    assign far     = (NEXT_BASE != 32'd0) && (req_addr >= NEXT_BASE[ADDR_W-1:0]);
    assign to_ctrl = (req_addr == ADDR_W'(CTRL_ADDR));
    assign to_nreg = (req_addr == ADDR_W'(NEXT_REG_ADDR));

    // R1: reset leaves the router idle with no pending handshake
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !exp_req_valid && req_ready));

    // R4: next-module word is answered without the register file
    assert_nextreg_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && to_nreg && !gated && !far |-> !loc_sel);

    assert_nextreg_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && to_nreg && !gated && !far && !req_write
        |=> rsp_valid && (rsp_rdata == DATA_W'(NEXT_BASE)) && !rsp_err);

    // R5: far requests reach the expansion port with the same address
    assert_far_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !gated && far |=> exp_req_valid && (exp_addr == $past(req_addr)));

    // R7: refused access has no side effect and flags an error
    assert_gate_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && gated && !to_ctrl |-> !loc_sel);

    assert_gate_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc && gated && !to_ctrl |=> !exp_req_valid && rsp_valid && rsp_err && (rsp_rdata == '0));

    // R8: control word always reaches the register file
    assert_ctrl_reach_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc && to_ctrl |-> loc_sel);

    // R9: one transaction in flight, response held under back-pressure
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

    // R10: expansion request held until taken
    assert_exp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exp_req_valid && !exp_req_ready
        |=> exp_req_valid && $stable(exp_addr) && $stable(exp_write) && $stable(exp_wdata));

endmodule

bind dbgbus_router dbgbus_router_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .NEXT_BASE     (NEXT_BASE),
    .CTRL_ADDR     (CTRL_ADDR),
    .NEXT_REG_ADDR (NEXT_REG_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sysrst_active (sysrst_active),
    .extrst_active (extrst_active),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_rdata     (rsp_rdata),
    .rsp_err       (rsp_err),
    .loc_sel       (loc_sel),
    .exp_req_valid (exp_req_valid),
    .exp_req_ready (exp_req_ready),
    .exp_addr      (exp_addr),
    .exp_write     (exp_write),
    .exp_wdata     (exp_wdata)
);

// File: tb/dbgbus_router_bench.sv
// Bench: directed scenarios for the debug bus access router.
module dbgbus_router_bench;

    localparam int AW = 7;
    localparam int DW = 32;
    localparam logic [DW-1:0] LOC_TAG = 32'hA5A5_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sysrst_active = 1'b0;
    logic extrst_active = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic [DW-1:0] rsp_rdata;
    logic rsp_err;
    logic loc_sel, loc_write;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata, loc_rdata;
    logic exp_req_valid;
    logic exp_req_ready = 1'b0;
    logic [AW-1:0] exp_addr;
    logic exp_write;
    logic [DW-1:0] exp_wdata;
    logic exp_rsp_valid = 1'b0;
    logic exp_rsp_ready;
    logic [DW-1:0] exp_rsp_rdata = '0;
    logic exp_rsp_err = 1'b0;

    // Second instance with no next module
    logic f_req_valid = 1'b0;
    logic f_req_ready, f_rsp_valid, f_rsp_err, f_loc_sel, f_loc_write;
    logic [DW-1:0] f_rsp_rdata, f_loc_wdata, f_loc_rdata, f_exp_wdata;
    logic [AW-1:0] f_loc_addr, f_exp_addr;
    logic f_exp_req_valid, f_exp_write, f_exp_rsp_ready;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Register-file model: read data is a tag plus the word address
    assign loc_rdata   = LOC_TAG | DW'(loc_addr);
    assign f_loc_rdata = LOC_TAG | DW'(f_loc_addr);

    dbgbus_router #(.ADDR_W(AW), .DATA_W(DW), .NEXT_BASE(32'h40)) u_dbgbus_router (
        .clk(clk), .rst_n(rst_n), .sysrst_active(sysrst_active), .extrst_active(extrst_active),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .loc_sel(loc_sel), .loc_write(loc_write), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .exp_req_valid(exp_req_valid), .exp_req_ready(exp_req_ready), .exp_addr(exp_addr),
        .exp_write(exp_write), .exp_wdata(exp_wdata), .exp_rsp_valid(exp_rsp_valid),
        .exp_rsp_ready(exp_rsp_ready), .exp_rsp_rdata(exp_rsp_rdata), .exp_rsp_err(exp_rsp_err)
    );

    dbgbus_router #(.ADDR_W(AW), .DATA_W(DW), .NEXT_BASE(32'h0)) u_dbgbus_router_flat (
        .clk(clk), .rst_n(rst_n), .sysrst_active(1'b0), .extrst_active(1'b0),
        .req_valid(f_req_valid), .req_ready(f_req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(f_rsp_valid), .rsp_ready(1'b1), .rsp_rdata(f_rsp_rdata), .rsp_err(f_rsp_err),
        .loc_sel(f_loc_sel), .loc_write(f_loc_write), .loc_addr(f_loc_addr),
        .loc_wdata(f_loc_wdata), .loc_rdata(f_loc_rdata),
        .exp_req_valid(f_exp_req_valid), .exp_req_ready(1'b1), .exp_addr(f_exp_addr),
        .exp_write(f_exp_write), .exp_wdata(f_exp_wdata), .exp_rsp_valid(1'b1),
        .exp_rsp_ready(f_exp_rsp_ready), .exp_rsp_rdata('0), .exp_rsp_err(1'b0)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one request from a negedge; ends at the negedge after accept
    task automatic issue(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                         output bit saw_loc, output bit saw_wr);
        @(negedge clk);
        req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
        #1;
        saw_loc = loc_sel;
        saw_wr  = loc_write;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Collect a response, holding rsp_ready low for 'hold' cycles first
    task automatic get_rsp(input int hold, output logic [DW-1:0] d, output logic e);
        int waited = 0;
        while (!rsp_valid && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_valid, "R9", "response arrives", DW'(rsp_valid), 1);
        chk(!req_ready, "R9", "busy while response pending", DW'(req_ready), 0);
        d = rsp_rdata; e = rsp_err;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_rdata == d && rsp_err == e, "R9", "response held",
                rsp_rdata, d);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9", "idle after handshake", DW'(rsp_valid), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R1", "rsp_valid in reset", DW'(rsp_valid), 0);
        chk(!exp_req_valid, "R1", "exp_req_valid in reset", DW'(exp_req_valid), 0);
        chk(req_ready, "R1", "req_ready in reset", DW'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_local_rw;
        bit sl, sw; logic [DW-1:0] d; logic e;
        issue(7'h05, 1'b0, '0, sl, sw);
        chk(sl && !sw, "R2", "local read strobe", DW'(sl), 1);
        get_rsp(3, d, e);
        chk(d == (LOC_TAG | 32'h05) && !e, "R2", "local read data", d, LOC_TAG | 32'h05);
        @(negedge clk);
        req_addr = 7'h22; req_write = 1'b1; req_wdata = 32'hCAFE_0022; req_valid = 1'b1;
        #1;
        chk(loc_sel && loc_write && loc_wdata == 32'hCAFE_0022, "R3", "local write strobe",
            loc_wdata, 32'hCAFE_0022);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        get_rsp(0, d, e);
        chk(d == '0 && !e, "R3", "local write response", d, 0);
    endtask

    task automatic t_nextreg;
        bit sl, sw; logic [DW-1:0] d; logic e;
        issue(7'h1D, 1'b0, '0, sl, sw);
        chk(!sl, "R4", "no strobe on next-module read", DW'(sl), 0);
        get_rsp(0, d, e);
        chk(d == 32'h40 && !e, "R4", "next-module value", d, 32'h40);
        issue(7'h1D, 1'b1, 32'hFF, sl, sw);
        chk(!sl, "R4", "no strobe on next-module write", DW'(sl), 0);
        get_rsp(0, d, e);
        chk(!e, "R4", "next-module write no error", DW'(e), 0);
        issue(7'h1D, 1'b0, '0, sl, sw);
        get_rsp(0, d, e);
        chk(d == 32'h40, "R4", "next-module value after write", d, 32'h40);
    endtask

    task automatic t_expand(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                            input logic [DW-1:0] rd, input logic er);
        bit sl, sw; logic [DW-1:0] d; logic e;
        issue(a, wr, wd, sl, sw);
        chk(!sl, "R5", "no local strobe for far address", DW'(sl), 0);
        chk(exp_req_valid && exp_addr == a && exp_write == wr, "R5", "forwarded address",
            DW'(exp_addr), DW'(a));
        if (wr) chk(exp_wdata == wd, "R5", "forwarded write data", exp_wdata, wd);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(exp_req_valid && exp_addr == a, "R10", "expansion request held",
                DW'(exp_addr), DW'(a));
        end
        exp_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exp_req_ready = 1'b0;
        chk(!exp_req_valid && exp_rsp_ready, "R10", "waiting for expansion answer",
            DW'(exp_rsp_ready), 1);
        exp_rsp_valid = 1'b1; exp_rsp_rdata = rd; exp_rsp_err = er;
        @(posedge clk);
        @(negedge clk);
        exp_rsp_valid = 1'b0;
        get_rsp(1, d, e);
        chk(d == rd && e == er, "R5", "expansion answer returned", d, rd);
    endtask

    task automatic t_boundary;
        bit sl, sw; logic [DW-1:0] d; logic e;
        issue(7'h3F, 1'b0, '0, sl, sw);
        chk(sl, "R2", "last local word is local", DW'(sl), 1);
        get_rsp(0, d, e);
        chk(d == (LOC_TAG | 32'h3F), "R2", "last local word data", d, LOC_TAG | 32'h3F);
        t_expand(7'h40, 1'b0, '0, 32'h1234_5678, 1'b0);
        t_expand(7'h7F, 1'b1, 32'hBEEF_0001, 32'h0, 1'b1);
    endtask

    task automatic t_gate;
        bit sl, sw; logic [DW-1:0] d; logic e;
        sysrst_active = 1'b1;
        issue(7'h11, 1'b0, '0, sl, sw);
        chk(!sl, "R7", "status word refused", DW'(sl), 0);
        get_rsp(0, d, e);
        chk(d == '0 && e, "R7", "refused read error", d, 0);
        issue(7'h05, 1'b1, 32'h55, sl, sw);
        chk(!sl, "R7", "refused write strobe", DW'(sl), 0);
        get_rsp(0, d, e);
        chk(e, "R7", "refused write error", DW'(e), 1);
        issue(7'h10, 1'b0, '0, sl, sw);
        chk(sl, "R8", "control word reachable under platform reset", DW'(sl), 1);
        get_rsp(0, d, e);
        chk(d == (LOC_TAG | 32'h10) && !e, "R8", "control read data", d, LOC_TAG | 32'h10);
        sysrst_active = 1'b0;
        extrst_active = 1'b1;
        issue(7'h50, 1'b0, '0, sl, sw);
        chk(!exp_req_valid, "R7", "far access refused", DW'(exp_req_valid), 0);
        get_rsp(0, d, e);
        chk(e && d == '0, "R7", "far refusal error", DW'(e), 1);
        issue(7'h10, 1'b1, 32'h1, sl, sw);
        chk(sl && sw, "R8", "control write under external reset", DW'(sl), 1);
        get_rsp(0, d, e);
        chk(!e, "R8", "control write no error", DW'(e), 0);
        extrst_active = 1'b0;
    endtask

    task automatic t_flat;
        logic [AW-1:0] addrs [3] = '{7'h50, 7'h7F, 7'h1D};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            req_addr = addrs[i]; req_write = 1'b0; f_req_valid = 1'b1;
            #1;
            chk(f_loc_sel == (i != 2), "R6", "flat routing strobe", DW'(f_loc_sel), DW'(i != 2));
            @(posedge clk);
            @(negedge clk);
            f_req_valid = 1'b0;
            chk(!f_exp_req_valid && f_rsp_valid, "R6", "flat no expansion", DW'(f_exp_req_valid), 0);
            chk(f_rsp_rdata == ((i == 2) ? '0 : (LOC_TAG | DW'(addrs[i]))), "R6",
                "flat read data", f_rsp_rdata, (i == 2) ? '0 : (LOC_TAG | DW'(addrs[i])));
        end
        @(negedge clk);
    endtask

    task automatic t_reset_midflight;
        bit sl, sw;
        issue(7'h44, 1'b0, '0, sl, sw);
        chk(exp_req_valid, "R10", "expansion pending before reset", DW'(exp_req_valid), 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(!exp_req_valid && !rsp_valid && req_ready, "R1", "reset drops pending request",
            DW'(exp_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_local_rw();
        t_nextreg();
        t_boundary();
        t_gate();
        t_flat();
        t_reset_midflight();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule